// File: doc/BRIEF.md
# Reciprocal Square-Root Estimator

This unit takes one IEEE-754 binary32 or binary64 operand and returns a coarse approximation of its reciprocal square root, good to about eight fraction bits. The caller chooses the format per operand with a precision flag. An 8-bit estimate comes from a 512-entry byte table. The table is computed during elaboration by an integer search. Its index joins the leading fraction bits of the normalised operand with the parity of its exponent. The result exponent is derived with integer arithmetic. Infinities, NaNs, zeros and subnormal operands each follow a fixed rule. A binary32 operand is widened to binary64 without loss, processed on the binary64 path, and narrowed back. The narrowing is always exact.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream, through a single output register. A transfer takes place on a rising edge where valid and ready are both high. The input side is ready whenever the output register is empty or is being drained in that same cycle. A stalled result therefore stops new operands without any loss. It also lets one operand per cycle flow through when the consumer keeps its ready signal high. Software uses the estimate as the seed for its own refinement.

Top module: `rsqrt_est`

## Requirements
- R1: The 8-bit estimate for table index i (128 to 511) is computed as follows. Let a = 2i+1 when i < 256, otherwise a = 2·(i OR 1). Let x be the smallest integer of at least 257 with a·x² ≥ 2^28. The entry is the low 8 bits of x >> 1.
- R2: A binary64 operand with exponent field 0x7FF and zero fraction (infinity) yields a zero that carries the operand's sign.
- R3: A NaN operand is returned with its most significant fraction bit (bit 51 in binary64, bit 22 in binary32) forced to 1. All its other bits stay unchanged.
- R4: An operand with zero exponent field and zero fraction yields infinity that carries the operand's sign.
- R5: A subnormal operand is normalised before lookup. Let k be the number of leading zeros of the 52-bit fraction. The exponent becomes −k, and the fraction is shifted left by k+1 bits.
- R6: With an odd adjusted exponent, the table index is 128 + fraction bits [51:45]. With an even adjusted exponent, it is 256 + fraction bits [51:44]. Parity is taken on the two's-complement value.
- R7: For finite non-zero operands, the result exponent field is the low 11 bits of floor((3068 − e) / 2), where e is the adjusted signed exponent.
- R8: A finite non-zero result keeps the operand's sign. Its fraction is the table entry in bits [51:44], and bits [43:0] are zero.
- R9: When the precision flag is 1, bits [31:0] of the operand are read as binary32. The result is that value widened to binary64, estimated, and narrowed back to binary32. Bits [63:32] of the result are zero. Example: 0x41200000 gives 0x3EA18000.
- R10: A result appears on the output one clock edge after its operand is accepted. The output goes empty after a transfer when no new operand is accepted in the same cycle.
- R11: While the output holds a result that is not taken, the output data stays unchanged and the input side is not ready. Taking the result and accepting a new operand can happen on the same edge.
- R12: After reset, the output holds no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_single | input | 1 | 1: binary32 in bits [31:0]; 0: binary64 |
| in_data | input | 64 | Operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result; upper half zero in binary32 mode |

## Verification
Every result is due at the first rising edge after the edge that accepts its operand. The bench drives each operand on a falling edge and waits for the accepting rising edge. It then reads out_valid and out_data on the following falling edge, where the result must already be present. During the stall test it reads the held result on every falling edge while out_ready is low. It then checks that the queued operand's result appears exactly one edge after ready returns, and that out_valid drops on the next edge.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  localparam int DEXP_W   = 11;
  localparam int DFRAC_W  = 52;
  localparam int DW       = 1 + DEXP_W + DFRAC_W;
  localparam int SEXP_W   = 8;
  localparam int SFRAC_W  = 23;
  localparam int SW       = 1 + SEXP_W + SFRAC_W;
  localparam int EST_W    = 8;
  localparam int IDX_W    = EST_W + 1;
  localparam int TBL_N    = 1 << IDX_W;
  localparam int XEXP_W   = DEXP_W + 2;
  localparam int SD_SHIFT = DFRAC_W - SFRAC_W;
  localparam int REBIAS   = 1023 - 127;
  localparam int EXP_K    = 3068;
  localparam int SEARCH_STEPS = 12;
  localparam int TARGET_LOG2  = 28;

  typedef enum logic [2:0] {
    RS_NORM,
    RS_SUB,
    RS_ZERO,
    RS_INF,
    RS_NAN
  } rs_kind_e;

  typedef logic [TBL_N-1:0][EST_W-1:0] rs_table_t;

  // Smallest x with a*x*x >= 2^28 by bisection, entry = x >> 1.
  function automatic logic [EST_W-1:0] est_entry(input int unsigned idx);
    longint unsigned a;
    longint unsigned lo;
    longint unsigned hi;
    longint unsigned mid;
    if (idx < (TBL_N / 4)) return '0;
    if (idx < (TBL_N / 2)) a = 2 * longint'(idx) + 1;
    else                   a = (longint'(idx) | 1) << 1;
    lo = 0;
    hi = 2048;
    for (int i = 0; i < SEARCH_STEPS; i++) begin
      if (lo < hi) begin
        mid = (lo + hi) >> 1;
        if (a * mid * mid >= (longint'(1) << TARGET_LOG2)) hi = mid;
        else                                              lo = mid + 1;
      end
    end
    return EST_W'(lo >> 1);
  endfunction

  function automatic rs_table_t build_table();
    rs_table_t t;
    for (int i = 0; i < TBL_N; i++) t[i] = est_entry(i);
    return t;
  endfunction

endpackage

// File: rtl/rsqrt_unpack.sv
module rsqrt_unpack
  import rsqrt_pkg::*;
(
  input  logic                     single_i,
  input  logic [DW-1:0]            data_i,
  output rs_kind_e                 kind_o,
  output logic                     sign_o,
  output logic signed [XEXP_W-1:0] exp_o,
  output logic [DFRAC_W-1:0]       frac_o
);

  logic [SEXP_W-1:0]  s_exp;
  logic [SFRAC_W-1:0] s_frac;
  logic [DEXP_W-1:0]  d_exp;
  logic [DFRAC_W-1:0] d_frac;
  logic               fmt_sign;

  assign s_exp    = data_i[SW-2 -: SEXP_W];
  assign s_frac   = data_i[SFRAC_W-1:0];
  assign d_exp    = data_i[DW-2 -: DEXP_W];
  assign d_frac   = data_i[DFRAC_W-1:0];
  assign fmt_sign = single_i ? data_i[SW-1] : data_i[DW-1];

  always_comb begin
    kind_o = RS_NORM;
    sign_o = fmt_sign;
    exp_o  = '0;
    frac_o = '0;
    if (single_i) begin
      frac_o = {s_frac, {SD_SHIFT{1'b0}}};
      if (&s_exp) begin
        kind_o = (|s_frac) ? RS_NAN : RS_INF;
        exp_o  = XEXP_W'({DEXP_W{1'b1}});
      end else if (s_exp == '0) begin
        kind_o = (|s_frac) ? RS_SUB : RS_ZERO;
        exp_o  = (|s_frac) ? XEXP_W'(REBIAS) : '0;
      end else begin
        kind_o = RS_NORM;
        exp_o  = XEXP_W'(s_exp) + XEXP_W'(REBIAS);
      end
    end else begin
      frac_o = d_frac;
      if (&d_exp) begin
        kind_o = (|d_frac) ? RS_NAN : RS_INF;
        exp_o  = XEXP_W'(d_exp);
      end else if (d_exp == '0) begin
        kind_o = (|d_frac) ? RS_SUB : RS_ZERO;
        exp_o  = '0;
      end else begin
        kind_o = RS_NORM;
        exp_o  = XEXP_W'(d_exp);
      end
    end
  end

endmodule

// File: rtl/rsqrt_norm.sv
module rsqrt_norm
  import rsqrt_pkg::*;
(
  input  logic                     is_sub_i,
  input  logic signed [XEXP_W-1:0] exp_i,
  input  logic [DFRAC_W-1:0]       frac_i,
  output logic signed [XEXP_W-1:0] exp_o,
  output logic [IDX_W-2:0]         top_o
);

  localparam int LZ_W = $clog2(DFRAC_W);

  logic [LZ_W-1:0] lz;
  logic            seen;

  always_comb begin
    lz   = '0;
    seen = 1'b0;
    for (int i = DFRAC_W - 1; i >= 0; i--) begin
      if (!seen && frac_i[i]) begin
        lz   = LZ_W'(DFRAC_W - 1 - i);
        seen = 1'b1;
      end
    end
  end

  always_comb begin
    if (is_sub_i) begin
      exp_o = exp_i - $signed({{(XEXP_W - LZ_W){1'b0}}, lz});
      top_o = (IDX_W - 1)'((frac_i << (lz + 1'b1)) >> (DFRAC_W - IDX_W + 1));
    end else begin
      exp_o = exp_i;
      top_o = frac_i[DFRAC_W-1 -: IDX_W-1];
    end
  end

endmodule

// File: rtl/rsqrt_core.sv
module rsqrt_core
  import rsqrt_pkg::*;
(
  input  logic signed [XEXP_W-1:0] exp_i,
  input  logic [IDX_W-2:0]         top_i,
  output logic [DEXP_W-1:0]        rexp_o,
  output logic [EST_W-1:0]         est_o
);

  localparam rs_table_t RS_TABLE = build_table();

  logic [IDX_W-1:0]         idx;
  logic signed [XEXP_W-1:0] diff;

  // Odd exponent folds into the lower half of the table, even into the upper.
  assign idx    = exp_i[0] ? {2'b01, top_i[IDX_W-2:1]} : {1'b1, top_i};
  assign diff   = XEXP_W'(EXP_K) - exp_i;
  assign rexp_o = DEXP_W'(diff >>> 1);
  assign est_o  = RS_TABLE[idx];

endmodule

// File: rtl/rsqrt_pack.sv
module rsqrt_pack
  import rsqrt_pkg::*;
(
  input  logic          single_i,
  input  logic [DW-1:0] dres_i,
  output logic [DW-1:0] res_o
);

  logic [DEXP_W-1:0] d_exp;
  logic [SEXP_W-1:0] s_exp;

  assign d_exp = dres_i[DW-2 -: DEXP_W];

  always_comb begin
    if (&d_exp)           s_exp = '1;
    else if (d_exp == '0) s_exp = '0;
    else                  s_exp = SEXP_W'(d_exp - DEXP_W'(REBIAS));
  end

  assign res_o = single_i
               ? {{(DW - SW){1'b0}}, dres_i[DW-1], s_exp, dres_i[DFRAC_W-1 -: SFRAC_W]}
               : dres_i;

endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqrt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_single,
  input  logic [63:0]   in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_data
);

  rs_kind_e                 kind;
  logic                     sign;
  logic signed [XEXP_W-1:0] exp_raw;
  logic signed [XEXP_W-1:0] exp_adj;
  logic [DFRAC_W-1:0]       frac;
  logic [IDX_W-2:0]         top;
  logic [DEXP_W-1:0]        rexp;
  logic [EST_W-1:0]         est;
  logic [DW-1:0]            dres;
  logic [DW-1:0]            res;
  logic                     take;

  rsqrt_unpack u_unpack (
    .single_i (in_single),
    .data_i   (in_data),
    .kind_o   (kind),
    .sign_o   (sign),
    .exp_o    (exp_raw),
    .frac_o   (frac)
  );

  rsqrt_norm u_norm (
    .is_sub_i (kind == RS_SUB),
    .exp_i    (exp_raw),
    .frac_i   (frac),
    .exp_o    (exp_adj),
    .top_o    (top)
  );

  rsqrt_core u_core (
    .exp_i  (exp_adj),
    .top_i  (top),
    .rexp_o (rexp),
    .est_o  (est)
  );

  always_comb begin
    unique case (kind)
      RS_INF:  dres = {sign, {(DW - 1){1'b0}}};
      RS_ZERO: dres = {sign, {DEXP_W{1'b1}}, {DFRAC_W{1'b0}}};
      RS_NAN:  dres = {sign, {DEXP_W{1'b1}}, frac | {1'b1, {(DFRAC_W - 1){1'b0}}}};
      default: dres = {sign, rexp, est, {(DFRAC_W - EST_W){1'b0}}};
    endcase
  end

  rsqrt_pack u_pack (
    .single_i (in_single),
    .dres_i   (dres),
    .res_o    (res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_single,
  input logic [63:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data
);

  logic acc;
  logic acc_d;
  assign acc   = in_valid && in_ready;
  assign acc_d = acc && !in_single;

  p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !acc) |=> !out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_d |=> (out_data[63] == $past(in_data[63])));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_d && (&in_data[62:52]) && (|in_data[51:0]))
      |=> (out_data[51] && (&out_data[62:52])));

  p_inf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_d && (&in_data[62:52]) && !(|in_data[51:0]))
      |=> (out_data[62:0] == 63'd0));

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_d && (in_data[62:0] == 63'd0))
      |=> (out_data[62:0] == {11'h7FF, 52'd0}));

  p_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_single) |=> (out_data[63:32] == 32'd0));

  p_reset_r12: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);

endmodule

bind rsqrt_est rsqrt_est_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_single (in_single),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/rsqrt_est_test.sv
module rsqrt_est_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_single = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int nchk = 0;
  int nerr = 0;
  byte unsigned tbl [512];

  always #2 clk = ~clk;

  rsqrt_est uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_single (in_single),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic byte unsigned ref_entry(input int idx);
    longint unsigned a;
    longint unsigned b;
    a = (idx < 256) ? (2 * longint'(idx) + 1) : ((longint'(idx) | 1) << 1);
    b = 256;
    while (a * (b + 1) * (b + 1) < (longint'(1) << 28)) b++;
    return byte'(((b + 1) >> 1) & 255);
  endfunction

  function automatic logic [63:0] ref_dbl(input logic [63:0] x);
    logic            s;
    longint          e;
    longint unsigned m;
    longint unsigned idx;
    longint unsigned re;
    s = x[63];
    e = longint'(x[62:52]);
    m = {12'd0, x[51:0]};
    if (e == 2047) begin
      if (m == 0) return {s, 63'd0};
      return x | (64'd1 << 51);
    end
    if (e == 0) begin
      if (m == 0) return {s, 11'h7FF, 52'd0};
      while (m[51] == 1'b0) begin
        m = m << 1;
        e = e - 1;
      end
      m = m << 1;
    end
    if (e[0]) idx = ((m >> 45) & 64'hFF) | 64'h80;
    else      idx = ((m >> 44) & 64'hFF) | 64'h100;
    re = longint'((3068 - e) / 2) & 64'h7FF;
    return {s, re[10:0], tbl[idx], 44'd0};
  endfunction

  function automatic logic [63:0] ref_rs(input logic single, input logic [63:0] x);
    logic [63:0] w;
    logic [63:0] r;
    logic [7:0]  e8;
    logic [22:0] f;
    int          n;
    logic [10:0] de;
    if (!single) return ref_dbl(x);
    e8 = x[30:23];
    f  = x[22:0];
    if (e8 == 8'hFF)      w = {x[31], 11'h7FF, f, 29'd0};
    else if (e8 == 8'd0) begin
      if (f == 0) w = {x[31], 63'd0};
      else begin
        logic [23:0] mm;
        mm = {1'b0, f};
        n = 0;
        while (!mm[23]) begin
          mm = mm << 1;
          n++;
        end
        w = {x[31], 11'(897 - n), mm[22:0], 29'd0};
      end
    end else w = {x[31], 11'(int'(e8) + 896), f, 29'd0};
    r  = ref_dbl(w);
    de = r[62:52];
    if (de == 11'h7FF)    e8 = 8'hFF;
    else if (de == 11'd0) e8 = 8'h00;
    else                  e8 = 8'(int'(de) - 896);
    return {32'd0, r[63], e8, r[51:29]};
  endfunction

  task automatic send(input logic s, input logic [63:0] x, output logic [63:0] y);
    @(negedge clk);
    in_valid  = 1'b1;
    in_single = s;
    in_data   = x;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    y = out_data;
    chk("R10 result one edge after accept", {63'd0, out_valid}, 64'd1);
  endtask

  function automatic string dbl_tag(input logic [10:0] e, input logic [51:0] f);
    if (e == 11'h7FF) return (f == 0) ? "R2 inf" : "R3 nan";
    if (e == 11'd0)   return (f == 0) ? "R4 zero" : "R5 subnormal";
    return "R7 normal";
  endfunction

  initial begin
    #(4 * 190000);
    nerr++;
    $display("FAIL watchdog expired got running expected finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [63:0] y;
    logic [63:0] a_exp;
    logic [63:0] b_exp;
    logic [51:0] dfr [6];
    logic [22:0] sfr [8];

    for (int i = 0; i < 512; i++) tbl[i] = (i >= 128) ? ref_entry(i) : 8'd0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R12 in_ready after reset", {63'd0, in_ready}, 64'd1);

    // R9 worked example
    send(1'b1, 64'h0000_0000_4120_0000, y);
    chk("R9 example 0x41200000", y, 64'h0000_0000_3EA1_8000);

    // R1 and R6: every table entry, odd and even parity
    for (int idx = 128; idx < 512; idx++) begin
      logic [63:0] x;
      if (idx >= 256) x = {1'b0, 11'd1024, idx[7:0], 44'd0};
      else            x = {1'b0, 11'd1023, idx[6:0], 45'd0};
      send(1'b0, x, y);
      chk("R1 R6 table entry", {56'd0, y[51:44]}, {56'd0, tbl[idx]});
      chk("R7 exponent for unit range", {53'd0, y[62:52]}, 64'd1022);
    end

    // R9 binary32 sweep over every exponent
    sfr = '{23'd0, 23'd1, 23'h400000, 23'h7FFFFF, 23'h200000, 23'h155555, 23'h000100, 23'h3AAAAA};
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 8; k++) begin
        for (int s = 0; s < 2; s++) begin
          logic [63:0] x;
          x = {32'd0, 1'(s), 8'(e), sfr[k]};
          send(1'b1, x, y);
          chk((e == 255) ? "R9 R3 single special" :
              (e == 0)   ? "R9 R5 single low" : "R9 single normal",
              y, ref_rs(1'b1, x));
        end
      end
    end

    // binary64 sweep over every exponent
    dfr = '{52'd0, 52'd1, 52'h8_0000_0000_0000, 52'hF_FFFF_FFFF_FFFF,
            52'h5_5555_5555_5555, 52'h0_0000_0010_0000};
    for (int e = 0; e < 2048; e++) begin
      for (int k = 0; k < 6; k++) begin
        for (int s = 0; s < 2; s++) begin
          logic [63:0] x;
          x = {1'(s), 11'(e), dfr[k]};
          send(1'b0, x, y);
          chk(dbl_tag(11'(e), dfr[k]), y, ref_rs(1'b0, x));
          if (e != 0 && e != 2047) begin
            chk("R8 sign and low fraction", {y[63], y[43:0]}, {1'(s), 44'd0});
          end
        end
      end
    end

    // R11 back-pressure with a queued operand
    a_exp = ref_rs(1'b0, 64'h4010_0000_0000_0000);
    b_exp = ref_rs(1'b1, 64'h0000_0000_4120_0000);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_single = 1'b0;
    in_data   = 64'h4010_0000_0000_0000;
    @(posedge clk);
    @(negedge clk);
    in_single = 1'b1;
    in_data   = 64'h0000_0000_4120_0000;
    for (int i = 0; i < 3; i++) begin
      chk("R11 result held", out_data, a_exp);
      chk("R11 valid held", {63'd0, out_valid}, 64'd1);
      chk("R11 input stalled", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 queued operand result", out_data, b_exp);
    chk("R10 valid after release", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R10 empty after drain", {63'd0, out_valid}, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule